// File: doc/BRIEF.md
# Caption Line Pulse and Field Flag Generator

This block sits behind a sync separator in a closed-caption receive path. It counts line-rate reference strobes from the start of each field and raises a line pulse while the line that carries caption data is on screen. A one-cycle slicer strobe marks the first clock of that line, and a field-parity flag tells the host which field the captured data belongs to. The host treats the falling edge of the line pulse as "caption data ready"; in the modes that capture both fields it samples the parity flag at that edge.

A two-bit mode input picks the caption line (21 or 22), whether both fields or only even fields produce a pulse, and where the line reference comes from. Normally that is the separated horizontal sync strobe. In the oscillator mode it is a divide-by-32 of tick strobes from an external ceramic oscillator near 508 kHz, which gives roughly the horizontal rate. In that mode the parity flag is forced low, because the pin that carries it is given over to the oscillator.

The sequencer has five states. `ST_SKIP` waits for a field start and ignores lines. `ST_WAIT` counts towards the caption line. `ST_MARK` is the first clock of the caption line. `ST_LINE` is the rest of that line. `ST_DONE` means the line has passed. On a field-start strobe, any state moves to `ST_WAIT` if the field qualifies and to `ST_SKIP` if it does not. The other transitions are:
- `ST_WAIT` to `ST_MARK` on the reference that brings the count to the caption line.
- `ST_MARK` to `ST_LINE` on a clock with no reference, or to `ST_DONE` on a reference.
- `ST_LINE` to `ST_DONE` on the next reference.
- `ST_SKIP` and `ST_DONE` stay put until the next field start.

Top module: `cc_line_gen`

## Requirements
- R1: `mode_pins` = {high pin, low pin} decodes as follows: 2'b00 is mode 1 (even fields, line 21, sync reference), 2'b01 is mode 2 (even fields, line 21, oscillator reference), 2'b10 is mode 3 (both fields, line 21), 2'b11 is mode 4 (both fields, line 22).
- R2: The line count becomes 1 one clock after `vsync_stb`. Each line reference strobe adds one. A `vsync_stb` in the same cycle as a reference wins, and that reference is not counted.
- R3: The line count saturates at 511. A field with no new `vsync_stb` never produces a second line pulse, however many references arrive.
- R4: In modes 1 and 2, the line pulse appears only on line 21 of fields whose `field_odd_in` was 0 at `vsync_stb`.
- R5: In mode 3, the line pulse appears on line 21 of every field.
- R6: In mode 4, the line pulse appears on line 22 of every field.
- R7: `line_pulse` rises one clock after the reference that makes the count equal the caption line, and falls one clock after the next reference or after a `vsync_stb`.
- R8: `slicer_stb` is high for exactly one clock per pulsed field: the first clock in which `line_pulse` is high.
- R9: In mode 2 the line reference is a one-clock strobe one clock after every 32nd `osc_tick`, and `hsync_stb` is ignored. In the other modes `osc_tick` is ignored and the divider is held at zero.
- R10: `field_odd_out` holds the `field_odd_in` value captured at the last `vsync_stb`, and is forced to 0 in mode 2.
- R11: After reset all outputs are 0, and no line pulse appears until the first `vsync_stb`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_pins | input | 2 | Operating mode select |
| hsync_stb | input | 1 | One-clock strobe per separated horizontal sync |
| vsync_stb | input | 1 | One-clock strobe at the start of each field |
| field_odd_in | input | 1 | Field parity from sync separation, 1 = odd |
| osc_tick | input | 1 | One-clock strobe per ceramic oscillator period |
| line_pulse | output | 1 | High for the duration of the caption line |
| field_odd_out | output | 1 | Parity of the current field |
| slicer_stb | output | 1 | One-clock marker at the start of the caption line |

## Verification
The bench builds the block with its defaults: a 9-bit line count, a 5-bit divider and caption lines 21 and 22. Every mode is swept against both field parities over the first 30 lines, and the pulse state is compared after each line with the value computed from the mode and line number. Because the count is only 9 bits wide, a 600-line field without a field start reaches saturation in a short run. The oscillator mode is run with a full 32-tick divider on every line, which makes the exact rising tick and the rejection of stray sync strobes observable.

// File: rtl/cc_line_pkg.sv
package cc_line_pkg;

    typedef enum logic [2:0] {
        ST_SKIP,
        ST_WAIT,
        ST_MARK,
        ST_LINE,
        ST_DONE
    } lp_state_e;

    typedef struct packed {
        logic osc_ref;      // line reference from oscillator divider
        logic both_fields;  // pulse on odd fields too
        logic line_sel_b;   // use the later caption line
        logic odd_valid;    // parity flag drives its output
    } mode_cfg_t;

endpackage

// File: rtl/cc_mode_decode.sv
module cc_mode_decode
    import cc_line_pkg::*;
(
    input  logic [1:0] mode_pins,
    output mode_cfg_t  cfg
);

    always_comb begin
        unique case (mode_pins)
            2'b00:   cfg = '{osc_ref: 1'b0, both_fields: 1'b0, line_sel_b: 1'b0, odd_valid: 1'b1};
            2'b01:   cfg = '{osc_ref: 1'b1, both_fields: 1'b0, line_sel_b: 1'b0, odd_valid: 1'b0};
            2'b10:   cfg = '{osc_ref: 1'b0, both_fields: 1'b1, line_sel_b: 1'b0, odd_valid: 1'b1};
            default: cfg = '{osc_ref: 1'b0, both_fields: 1'b1, line_sel_b: 1'b1, odd_valid: 1'b1};
        endcase
    end

endmodule

// File: rtl/cc_ref_divider.sv
module cc_ref_divider #(
    parameter int DIV_W = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic osc_tick,
    output logic div_stb
);

    localparam logic [DIV_W-1:0] DIV_LAST = {DIV_W{1'b1}};

    logic [DIV_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            cnt     <= '0;
            div_stb <= 1'b0;
        end else begin
            div_stb <= osc_tick && (cnt == DIV_LAST);
            if (osc_tick) begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    // R9: a divider strobe is seen only right after the count wrapped
    assert_div_phase_R9: assert property (@(posedge clk) disable iff (!rst_n)
        div_stb |-> (cnt == '0));

    // R9: strobes are a single clock wide
    assert_div_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        div_stb |=> !div_stb);

endmodule

// File: rtl/cc_line_counter.sv
module cc_line_counter #(
    parameter int LINE_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vsync_stb,
    input  logic              field_odd_in,
    input  logic              ref_stb,
    output logic [LINE_W-1:0] line_cnt,
    output logic              field_odd_q
);

    localparam logic [LINE_W-1:0] LINE_MAX = {LINE_W{1'b1}};
    localparam logic [LINE_W-1:0] LINE_ONE = LINE_W'(1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_cnt    <= '0;
            field_odd_q <= 1'b0;
        end else if (vsync_stb) begin
            line_cnt    <= LINE_ONE;
            field_odd_q <= field_odd_in;
        end else if (ref_stb && (line_cnt != LINE_MAX)) begin
            line_cnt <= line_cnt + 1'b1;
        end
    end

    // R2: a field start restarts the count at one
    assert_field_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
        vsync_stb |=> (line_cnt == LINE_ONE));

    // R3: the count never wraps past its maximum
    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (line_cnt == LINE_MAX) && !vsync_stb |=> (line_cnt == LINE_MAX));

endmodule

// File: rtl/cc_line_fsm.sv
module cc_line_fsm
    import cc_line_pkg::*;
#(
    parameter int LINE_W = 9,
    parameter int LINE_A = 21,
    parameter int LINE_B = 22
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vsync_stb,
    input  logic              field_odd_in,
    input  logic              field_odd_q,
    input  logic              ref_stb,
    input  logic [LINE_W-1:0] line_cnt,
    input  mode_cfg_t         cfg,
    output logic              line_pulse,
    output logic              slicer_stb
);

    localparam logic [LINE_W-1:0] TGT_A    = LINE_W'(LINE_A);
    localparam logic [LINE_W-1:0] TGT_B    = LINE_W'(LINE_B);
    localparam logic [LINE_W-1:0] PRE_A    = LINE_W'(LINE_A - 1);
    localparam logic [LINE_W-1:0] PRE_B    = LINE_W'(LINE_B - 1);

    lp_state_e         state, state_nx;
    logic [LINE_W-1:0] target, pre_target;
    logic              field_ok;

    assign target     = cfg.line_sel_b ? TGT_B : TGT_A;
    assign pre_target = cfg.line_sel_b ? PRE_B : PRE_A;
    assign field_ok   = cfg.both_fields || !field_odd_in;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_SKIP;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx = state;
        if (vsync_stb) begin
            state_nx = field_ok ? ST_WAIT : ST_SKIP;
        end else begin
            unique case (state)
                ST_SKIP: state_nx = ST_SKIP;
                ST_WAIT: if (ref_stb && (line_cnt == pre_target)) state_nx = ST_MARK;
                ST_MARK: state_nx = ref_stb ? ST_DONE : ST_LINE;
                ST_LINE: if (ref_stb) state_nx = ST_DONE;
                ST_DONE: state_nx = ST_DONE;
                default: state_nx = ST_SKIP;
            endcase
        end
    end

    always_comb begin
        line_pulse = 1'b0;
        slicer_stb = 1'b0;
        unique case (state)
            ST_MARK: begin
                line_pulse = 1'b1;
                slicer_stb = 1'b1;
            end
            ST_LINE: line_pulse = 1'b1;
            default: ;
        endcase
    end

    // R4 R5 R6: the pulse sits on the selected line only
    assert_pulse_on_target_R6: assert property (@(posedge clk) disable iff (!rst_n)
        line_pulse |-> (line_cnt == target));

    // R4: even-only modes never pulse in an odd field
    assert_even_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
        line_pulse && !cfg.both_fields |-> !field_odd_q);

    // R8: the slicer marker lasts one clock
    assert_slicer_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        slicer_stb |=> !slicer_stb);

    // R7: a field start ends any pulse
    assert_vsync_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        vsync_stb |=> !line_pulse);

endmodule

// File: rtl/cc_line_gen.sv
module cc_line_gen
    import cc_line_pkg::*;
#(
    parameter int LINE_W = 9,
    parameter int DIV_W  = 5,
    parameter int LINE_A = 21,
    parameter int LINE_B = 22
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] mode_pins,
    input  logic       hsync_stb,
    input  logic       vsync_stb,
    input  logic       field_odd_in,
    input  logic       osc_tick,
    output logic       line_pulse,
    output logic       field_odd_out,
    output logic       slicer_stb
);

    mode_cfg_t         cfg;
    logic              div_stb;
    logic              ref_stb;
    logic [LINE_W-1:0] line_cnt;
    logic              field_odd_q;

    cc_mode_decode u_decode (
        .mode_pins (mode_pins),
        .cfg       (cfg)
    );

    cc_ref_divider #(.DIV_W(DIV_W)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (cfg.osc_ref),
        .osc_tick (osc_tick),
        .div_stb  (div_stb)
    );

    assign ref_stb = cfg.osc_ref ? div_stb : hsync_stb;

    cc_line_counter #(.LINE_W(LINE_W)) u_count (
        .clk          (clk),
        .rst_n        (rst_n),
        .vsync_stb    (vsync_stb),
        .field_odd_in (field_odd_in),
        .ref_stb      (ref_stb),
        .line_cnt     (line_cnt),
        .field_odd_q  (field_odd_q)
    );

    cc_line_fsm #(
        .LINE_W (LINE_W),
        .LINE_A (LINE_A),
        .LINE_B (LINE_B)
    ) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .vsync_stb    (vsync_stb),
        .field_odd_in (field_odd_in),
        .field_odd_q  (field_odd_q),
        .ref_stb      (ref_stb),
        .line_cnt     (line_cnt),
        .cfg          (cfg),
        .line_pulse   (line_pulse),
        .slicer_stb   (slicer_stb)
    );

    assign field_odd_out = field_odd_q & cfg.odd_valid;

    // R9: in oscillator mode a lone sync strobe leaves the count alone
    assert_hsync_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cfg.osc_ref && hsync_stb && !div_stb && !vsync_stb |=> $stable(line_cnt));

    // R8: the slicer marker always falls inside the line pulse
    assert_slicer_in_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        slicer_stb |-> line_pulse);

endmodule

// File: tb/cc_line_gen_bench.sv
module cc_line_gen_bench;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] mode_pins = 2'b00;
    logic       hsync_stb = 1'b0;
    logic       vsync_stb = 1'b0;
    logic       field_odd_in = 1'b0;
    logic       osc_tick = 1'b0;
    logic       line_pulse, field_odd_out, slicer_stb;

    int  checks = 0;
    int  errors = 0;
    int  slicer_cnt = 0;
    bit  finished = 1'b0;
    logic prev_pulse = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    cc_line_gen u_cc_line_gen (
        .clk           (clk),
        .rst_n         (rst_n),
        .mode_pins     (mode_pins),
        .hsync_stb     (hsync_stb),
        .vsync_stb     (vsync_stb),
        .field_odd_in  (field_odd_in),
        .osc_tick      (osc_tick),
        .line_pulse    (line_pulse),
        .field_odd_out (field_odd_out),
        .slicer_stb    (slicer_stb)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // R8 monitor: marker counted, and must open the pulse
    always @(negedge clk) begin
        if (rst_n && slicer_stb) begin
            slicer_cnt++;
            chk("R8 marker on first pulse clock", {prev_pulse, line_pulse}, 1);
        end
        prev_pulse = line_pulse;
    end

    task automatic do_vsync(input logic odd, input logic with_ref);
        @(negedge clk);
        vsync_stb    = 1'b1;
        field_odd_in = odd;
        hsync_stb    = with_ref;
        @(negedge clk);
        vsync_stb = 1'b0;
        hsync_stb = 1'b0;
        @(negedge clk);
    endtask

    task automatic osc_ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); osc_tick = 1'b1;
            @(negedge clk); osc_tick = 1'b0;
        end
    endtask

    task automatic hs_line(input logic stray_osc);
        @(negedge clk); hsync_stb = 1'b1;
        @(negedge clk); hsync_stb = 1'b0;
        if (stray_osc) osc_ticks(3);
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic osc_line(input bit mid_check, input int exp_mid);
        osc_ticks(15);
        @(negedge clk); hsync_stb = 1'b1;   // stray sync, R9
        @(negedge clk); hsync_stb = 1'b0;
        osc_ticks(16);
        if (mid_check) chk("R9 no rise before 32nd tick", int'(line_pulse), exp_mid);
        osc_ticks(1);
        @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int hits;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11 reset state and no pulse before a field start
        chk("R11 pulse after reset", int'(line_pulse), 0);
        chk("R11 parity after reset", int'(field_odd_out), 0);
        chk("R11 marker after reset", int'(slicer_stb), 0);
        mode_pins = 2'b10;
        hits = 0;
        for (int l = 0; l < 30; l++) begin
            hs_line(1'b0);
            hits += int'(line_pulse);
        end
        chk("R11 no pulse before vsync", hits, 0);

        // R1 R4 R5 R6 R7 R9 R10: sweep every mode and parity
        for (int m = 0; m < 4; m++) begin
            for (int odd = 0; odd < 2; odd++) begin
                int tgt;
                bit qual;
                mode_pins = 2'(m);
                tgt  = (m == 3) ? 22 : 21;
                qual = (m >= 2) || (odd == 0);
                slicer_cnt = 0;
                do_vsync(odd[0], 1'b0);
                chk("R10 parity flag", int'(field_odd_out), (m == 1) ? 0 : odd);
                chk("R7 no pulse on line 1", int'(line_pulse), 0);
                for (int l = 2; l <= 30; l++) begin
                    int exp;
                    exp = (qual && (l == tgt)) ? 1 : 0;
                    if (m == 1) osc_line((l == 21), (qual && (tgt == 20)) ? 1 : 0);
                    else        hs_line(1'b1);
                    if (m == 3)      chk("R6 line pulse mode 4", int'(line_pulse), exp);
                    else if (m == 2) chk("R5 line pulse mode 3", int'(line_pulse), exp);
                    else             chk("R4 line pulse even-only", int'(line_pulse), exp);
                end
                chk("R8 markers per field", slicer_cnt, qual ? 1 : 0);
            end
        end

        // R2: vsync beats a simultaneous reference
        mode_pins = 2'b10;
        do_vsync(1'b1, 1'b1);
        for (int l = 2; l <= 21; l++) begin
            hs_line(1'b0);
            chk("R2 count after vsync with ref", int'(line_pulse), (l == 21) ? 1 : 0);
        end

        // R7: a vsync during the pulse ends it
        do_vsync(1'b0, 1'b0);
        chk("R7 vsync ends pulse", int'(line_pulse), 0);
        chk("R10 parity recaptured", int'(field_odd_out), 0);

        // R3: long field, single pulse
        mode_pins = 2'b11;
        do_vsync(1'b1, 1'b0);
        hits = 0;
        for (int l = 0; l < 600; l++) begin
            hs_line(1'b0);
            hits += int'(line_pulse);
        end
        chk("R3 single pulse in long field", hits, 1);
        do_vsync(1'b0, 1'b0);
        for (int l = 2; l <= 22; l++) hs_line(1'b0);
        chk("R3 recovers after saturation", int'(line_pulse), 1);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule